// File: doc/BRIEF.md
# Raster Pixel Serializer with Speed and Inversion Mode

The serializer turns parallel display words into the one-bit pixel stream of a monochrome raster. At every word boundary it raises a one-cycle unload strobe toward a word buffer and takes the word that the buffer presents in that same cycle, together with its valid flag. Between boundaries it shifts the held word out, most significant bit first. An empty buffer yields a word time of background pixels. A blanking input, driven by the raster timing logic, forces the pixel to background without disturbing the shift sequence.

A 16-bit bus write sets a small mode state. One bit selects half-rate pixel pacing, in which each pixel lasts two bit clocks and a word lasts 32 clocks. A second bit selects inverse video, in which every loaded word is complemented before it is shifted. A new mode is held as pending and applies only from the next word boundary, so no word is ever split between two modes. The surrounding chip uses this block at the end of the display path: timing logic drives the blanking input, and a word store answers the unload strobe.

Top module: `pixser`

## Requirements
- R1: After reset the pixel output is 0, and unload stays low until the first word boundary, which falls in the 16th bit clock after reset is released.
- R2: In normal pacing, unload is high for exactly one clock in every 16 clocks.
- R3: A loaded word leaves most significant bit first, one bit per clock in normal pacing, starting in the clock after the unload cycle.
- R4: When the speed bit (mode_bus bit 15) is 1, each pixel is held for two clocks and unload comes once every 32 clocks.
- R5: When the inverse bit (mode_bus bit 14) is 1, each valid word is complemented before it is shifted out.
- R6: If word_valid is low in an unload cycle, the following word time shows only background pixels (0).
- R7: While blank is high, pix_out is 0. The shift sequence keeps running, so pixels after blanking ends are those that are due at that time.
- R8: A mode write applies from the first word boundary after the write cycle. A write made in a boundary cycle does not affect the word loaded at that boundary.
- R9: Mode bus bits other than bits 15 and 14 have no effect.
- R10: word_data is sampled only in an unload cycle, and its value in any other cycle has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Mode write strobe |
| mode_bus | input | 16 | Mode value; bit 15 selects half speed, bit 14 selects inverse video |
| word_data | input | 16 | Next display word from the buffer |
| word_valid | input | 1 | word_data holds a real word |
| blank | input | 1 | Horizontal or vertical blanking active |
| pix_out | output | 1 | Serial pixel, 1 = lit |
| unload | output | 1 | One-cycle request that takes the presented word |

## Verification
The assertions assume that the word source answers unload in the same cycle, with word_data and word_valid already settled. They also assume that a mode write is a single-cycle strobe with its bus value stable in that cycle. The stimulus changes all inputs only at the falling clock edge. It holds reset long enough for every register to clear. It places mode writes both inside a word and exactly on a boundary cycle, and it fills the non-unload cycles with random junk words, so the sampling window is exercised without ever being made ambiguous.

// File: rtl/pixser_pkg.sv
package pixser_pkg;
   // pending mode as written from the bus
   typedef struct packed {
      logic slow;
      logic inv;
   } pixser_mode_t;
endpackage

// File: rtl/pixser_pacer.sv
// Pixel pacing: a phase divider for half-rate mode and a bit counter that
// marks the last pixel step of a word time.
module pixser_pacer #(
   parameter int WORD_W   = 16,
   parameter int SLOW_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic slow,
   output logic step,
   output logic boundary
);
   localparam int CNT_W = $clog2(WORD_W);
   localparam int PH_W  = $clog2(SLOW_DIV);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);
   localparam logic [PH_W-1:0]  LAST_PH  = PH_W'(SLOW_DIV - 1);

   logic [CNT_W-1:0] bit_cnt;
   logic [PH_W-1:0]  phase;

   assign step     = !slow || (phase == LAST_PH);
   assign boundary = step && (bit_cnt == LAST_BIT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bit_cnt <= '0;
         phase   <= '0;
      end else if (boundary) begin
         bit_cnt <= '0;
         phase   <= '0;
      end else begin
         if (step)
            bit_cnt <= bit_cnt + 1'b1;
         phase <= (slow && !step) ? phase + 1'b1 : '0;
      end
   end
endmodule

// File: rtl/pixser_mode.sv
// Mode holding: bus writes land in a pending copy, and the pacing choice is
// moved into the active copy only at a word boundary.
module pixser_mode
   import pixser_pkg::*;
(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic         speed_in,
   input  logic         inv_in,
   input  logic         boundary,
   output pixser_mode_t pend,
   output logic         act_slow
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend     <= '0;
         act_slow <= 1'b0;
      end else begin
         if (boundary)
            act_slow <= pend.slow;
         if (wr) begin
            pend.slow <= speed_in;
            pend.inv  <= inv_in;
         end
      end
   end
endmodule

// File: rtl/pixser_shifter.sv
// Word shift register: loads at a boundary (complemented when inverted,
// zero when no word), shifts toward the MSB on each pixel step.
module pixser_shifter #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic              boundary,
   input  logic              load_valid,
   input  logic [WORD_W-1:0] load_word,
   input  logic              invert,
   input  logic              blank,
   output logic              pix
);
   logic [WORD_W-1:0] sh_q;
   logic [WORD_W-1:0] sh_next;

   generate
      for (genvar i = 0; i < WORD_W; i++) begin : g_lane
         if (i == 0) begin : g_fill
            assign sh_next[i] = 1'b0;
         end else begin : g_move
            assign sh_next[i] = sh_q[i-1];
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         sh_q <= '0;
      else if (boundary)
         sh_q <= load_valid ? (load_word ^ {WORD_W{invert}}) : '0;
      else if (step)
         sh_q <= sh_next;
   end

   assign pix = sh_q[WORD_W-1] & ~blank;
endmodule

// File: rtl/pixser.sv
module pixser
   import pixser_pkg::*;
#(
   parameter int WORD_W    = 16,
   parameter int MODE_W    = 16,
   parameter int SPEED_BIT = 15,
   parameter int INV_BIT   = 14,
   parameter int SLOW_DIV  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_wr,
   input  logic [MODE_W-1:0] mode_bus,
   input  logic [WORD_W-1:0] word_data,
   input  logic              word_valid,
   input  logic              blank,
   output logic              pix_out,
   output logic              unload
);
   localparam logic [MODE_W-1:0] USED_MASK =
      (MODE_W'(1) << SPEED_BIT) | (MODE_W'(1) << INV_BIT);

   generate
      if (WORD_W < 2) begin : g_bad_word
         $error("pixser: WORD_W must be at least 2");
      end
      if (SLOW_DIV < 2) begin : g_bad_div
         $error("pixser: SLOW_DIV must be at least 2");
      end
      if (SPEED_BIT >= MODE_W || INV_BIT >= MODE_W || SPEED_BIT == INV_BIT) begin : g_bad_bits
         $error("pixser: mode bit positions must be distinct and inside the bus");
      end
   endgenerate

   logic [MODE_W-1:0] ignored_bits_unused;
   assign ignored_bits_unused = mode_bus & ~USED_MASK;

   pixser_mode_t pend;
   logic         act_slow;
   logic         step;
   logic         boundary;

   pixser_mode u_mode (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (mode_wr),
      .speed_in (mode_bus[SPEED_BIT]),
      .inv_in   (mode_bus[INV_BIT]),
      .boundary (boundary),
      .pend     (pend),
      .act_slow (act_slow)
   );

   pixser_pacer #(.WORD_W(WORD_W), .SLOW_DIV(SLOW_DIV)) u_pacer (
      .clk      (clk),
      .rst_n    (rst_n),
      .slow     (act_slow),
      .step     (step),
      .boundary (boundary)
   );

   pixser_shifter #(.WORD_W(WORD_W)) u_shifter (
      .clk        (clk),
      .rst_n      (rst_n),
      .step       (step),
      .boundary   (boundary),
      .load_valid (word_valid),
      .load_word  (word_data),
      .invert     (pend.inv),
      .blank      (blank),
      .pix        (pix_out)
   );

   assign unload = boundary;
endmodule

// File: rtl/pixser_checker.sv
module pixser_checker #(
   parameter int WORD_W   = 16,
   parameter int SLOW_DIV = 2
) (
   input logic clk,
   input logic rst_n,
   input logic mode_wr,
   input logic mode_inv,
   input logic word_msb,
   input logic word_valid,
   input logic blank,
   input logic pix_out,
   input logic unload
);
   localparam int GAP_W = $clog2(WORD_W * SLOW_DIV) + 1;
   localparam logic [GAP_W-1:0] GAP_FAST = GAP_W'(WORD_W - 1);
   localparam logic [GAP_W-1:0] GAP_SLOW = GAP_W'(WORD_W * SLOW_DIV - 1);

   logic [GAP_W-1:0] gap;
   logic             seen_unload;
   logic             inv_shadow;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gap         <= '0;
         seen_unload <= 1'b0;
         inv_shadow  <= 1'b0;
      end else begin
         gap <= unload ? '0 : gap + 1'b1;
         if (unload)
            seen_unload <= 1'b1;
         if (mode_wr)
            inv_shadow <= mode_inv;
      end
   end

   assert_dark_before_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_unload |-> !pix_out);

   assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      unload |=> !unload);

   assert_word_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
      unload |-> (gap == GAP_FAST || gap == GAP_SLOW));

   assert_first_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (unload && word_valid) |=> (blank || pix_out == ($past(word_msb) ^ $past(inv_shadow))));

   assert_empty_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (unload && !word_valid) |=> !pix_out);

   assert_blank_dark_R7: assert property (@(posedge clk) disable iff (!rst_n)
      blank |-> !pix_out);
endmodule

bind pixser pixser_checker #(.WORD_W(WORD_W), .SLOW_DIV(SLOW_DIV)) u_pixser_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .mode_wr    (mode_wr),
   .mode_inv   (mode_bus[INV_BIT]),
   .word_msb   (word_data[WORD_W-1]),
   .word_valid (word_valid),
   .blank      (blank),
   .pix_out    (pix_out),
   .unload     (unload)
);

// File: tb/pixser_bench.sv
`timescale 1ns/1ps
module pixser_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_wr = 1'b0;
   logic [15:0] mode_bus = '0;
   logic [15:0] word_data = '0;
   logic        word_valid = 1'b0;
   logic        blank = 1'b0;
   logic        pix_out;
   logic        unload;

   int    vectors = 0;
   int    miscompares = 0;
   string cur_req = "R1";

   // reference state, derived from the requirements
   logic [15:0] m_sh = '0;
   int          m_cnt = 0;
   logic        m_ph = 1'b0;
   logic        m_half = 1'b0;
   logic        m_phalf = 1'b0;
   logic        m_pinv = 1'b0;

   always #4 clk = ~clk;

   pixser u_pixser (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_wr    (mode_wr),
      .mode_bus   (mode_bus),
      .word_data  (word_data),
      .word_valid (word_valid),
      .blank      (blank),
      .pix_out    (pix_out),
      .unload     (unload)
   );

   function automatic logic due();
      return (m_cnt == 15) && (!m_half || m_ph);
   endfunction

   task automatic apply(input logic wr, input logic [15:0] bus,
                        input logic [15:0] w, input logic v, input logic b);
      logic exp_unl;
      logic exp_pix;
      logic stp;
      mode_wr = wr; mode_bus = bus; word_data = w; word_valid = v; blank = b;
      #1;
      exp_unl = due();
      exp_pix = m_sh[15] && !b;
      vectors++;
      if (unload !== exp_unl || pix_out !== exp_pix) begin
         miscompares++;
         $display("FAIL %s: unload=%b pix_out=%b, expected unload=%b pix_out=%b",
                  cur_req, unload, pix_out, exp_unl, exp_pix);
      end
      @(posedge clk);
      stp = !m_half || m_ph;
      if (exp_unl) begin
         m_sh   = v ? (w ^ {16{m_pinv}}) : 16'h0000;
         m_half = m_phalf;
         m_cnt  = 0;
         m_ph   = 1'b0;
      end else if (stp) begin
         m_sh  = m_sh << 1;
         m_cnt = m_cnt + 1;
         m_ph  = 1'b0;
      end else begin
         m_ph = 1'b1;
      end
      if (wr) begin
         m_phalf = bus[15];
         m_pinv  = bus[14];
      end
      @(negedge clk);
   endtask

   task automatic run(input int n, input logic [15:0] w, input logic v, input logic b);
      for (int i = 0; i < n; i++) apply(1'b0, 16'h0000, w, v, b);
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
   endtask

   initial begin
      #(200000 * 8);
      miscompares++;
      $display("FAIL watchdog (all requirements): run still active, expected it to end");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1: quiet after reset until the first boundary
      cur_req = "R1";
      run(16, 16'hFFFF, 1'b1, 1'b0);

      // R2: one-cycle unload every 16 clocks
      cur_req = "R2";
      run(48, 16'hA5C3, 1'b1, 1'b0);

      // R3: MSB first, one bit per clock
      cur_req = "R3";
      run(32, 16'h8001, 1'b1, 1'b0);
      run(32, 16'h7FFE, 1'b1, 1'b0);

      // R10: junk outside unload cycles has no effect
      cur_req = "R10";
      for (int i = 0; i < 48; i++)
         apply(1'b0, 16'h0000, due() ? 16'h00FF : 16'($urandom), 1'b1, 1'b0);

      // R5: inverse video written mid-word
      cur_req = "R5";
      run(5, 16'h1234, 1'b1, 1'b0);
      apply(1'b1, 16'h4000, 16'h1234, 1'b1, 1'b0);
      run(40, 16'h1234, 1'b1, 1'b0);

      // R8: write exactly in a boundary cycle
      cur_req = "R8";
      while (!due()) apply(1'b0, 16'h0000, 16'h0F0F, 1'b1, 1'b0);
      apply(1'b1, 16'h0000, 16'h0F0F, 1'b1, 1'b0);
      run(36, 16'h0F0F, 1'b1, 1'b0);

      // R4: half-rate pacing
      cur_req = "R4";
      apply(1'b1, 16'h8000, 16'hC3A5, 1'b1, 1'b0);
      run(100, 16'hC3A5, 1'b1, 1'b0);
      while (!due()) apply(1'b0, 16'h0000, 16'hC3A5, 1'b1, 1'b0);
      apply(1'b1, 16'hC000, 16'h6DB6, 1'b1, 1'b0);
      run(70, 16'h6DB6, 1'b1, 1'b0);

      // R9: other mode bits ignored (all set, speed and inverse clear)
      cur_req = "R9";
      apply(1'b1, 16'h3FFF, 16'hF00D, 1'b1, 1'b0);
      run(80, 16'hF00D, 1'b1, 1'b0);

      // R6: empty buffer gives a background word
      cur_req = "R6";
      run(40, 16'hFFFF, 1'b0, 1'b0);
      run(20, 16'hFFFF, 1'b1, 1'b0);

      // R7: blanking forces background, shift keeps running
      cur_req = "R7";
      for (int i = 0; i < 60; i++)
         apply(1'b0, 16'h0000, 16'hFFFF, 1'b1, (i % 5) < 2);

      // mixed random traffic
      cur_req = "R2";
      for (int i = 0; i < 3000; i++)
         apply(($urandom % 20) == 0, 16'($urandom), 16'($urandom),
               ($urandom % 4) != 0, ($urandom % 8) == 0);

      summary();
      $finish;
   end
endmodule